// File: doc/BRIEF.md
# Vector Lane Permute Unit

The unit rearranges a wide vector by lanes. A 256-bit data vector and a 256-bit index vector each split into eight 32-bit lanes. Every output lane takes a copy of the data lane named by the matching index lane. Only the low three bits of each index lane select a source lane. Any data lane may feed several output lanes, so the unit can broadcast as well as reorder. Lane contents pass through untouched. No floating-point meaning is given to them, and no arithmetic flags are raised.

Two encoding control bits arrive with each request: a full-length bit and a wide-element bit. A request is legal only when the full-length bit is 1 and the wide-element bit is 0. An illegal request raises the fault flag and forces the result to zero, so a consumer must not treat that result as a valid write. A parameter selects an output register stage. With the stage, valid, fault and result appear one cycle after the request. Without it, they follow the inputs in the same cycle.

Top module: `lane_permute_unit`

## Requirements
- R1: Output lane i (bits 32i+31..32i) equals data lane k, where k is the unsigned value of bits 32i+2..32i of the index vector.
- R2: Bits 31..3 of every index lane have no effect on the result.
- R3: One data lane may be copied to any number of output lanes in the same request.
- R4: A valid request with the full-length bit at 0 raises out_fault.
- R5: A valid request with the wide-element bit at 1 raises out_fault.
- R6: When out_fault is 1, out_result is all zeros. A request is legal, and gives no fault, only when the full-length bit is 1 and the wide-element bit is 0.
- R7: Lane bit patterns are copied exactly, including all-ones, NaN-like and denormal-like patterns.
- R8: With REG_OUT=1, out_valid, out_fault and out_result reflect the request from the previous clock edge. With REG_OUT=0, they reflect the current inputs.
- R9: While rst_n is 0, out_valid and out_fault are 0.
- R10: out_fault is 1 only together with out_valid. A cycle with in_valid at 0 never faults, whatever the control bits are.
- R11: With REG_OUT=1, out_result holds its last value in cycles when in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe |
| in_data | input | 256 | Source vector, eight 32-bit lanes |
| in_index | input | 256 | Index vector, eight 32-bit lanes |
| in_len_full | input | 1 | Full-length encoding bit; must be 1 |
| in_wide_elem | input | 1 | Wide-element encoding bit; must be 0 |
| out_valid | output | 1 | Result strobe |
| out_result | output | 256 | Permuted vector, zero on fault |
| out_fault | output | 1 | Illegal-encoding flag |

## Verification
The bench builds two copies side by side on the same stimulus. One uses REG_OUT=1 and the default eight 32-bit lanes. The other uses REG_OUT=0. Together they reach both the one-cycle and the same-cycle timing, the hold behaviour of the result register, and the asynchronous clear. Both copies use the full lane count, so every output lane and all eight select values are reached with random data and random upper index bits. All four combinations of the control bits are covered.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

  localparam int unsigned DEF_LANES  = 8;
  localparam int unsigned DEF_LANE_W = 32;

  // encoding control bits that travel with a request
  typedef struct packed {
    logic len_full;
    logic wide_elem;
  } lperm_enc_t;

  // legality verdict for one request
  typedef enum logic [1:0] {
    ENC_OK    = 2'b00,
    ENC_SHORT = 2'b01,
    ENC_WIDE  = 2'b10,
    ENC_BOTH  = 2'b11
  } lperm_enc_e;

endpackage

// File: rtl/lperm_index_decode.sv
module lperm_index_decode
  import lperm_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned SEL_W  = $clog2(DEF_LANES)
) (
  input  logic [LANES*LANE_W-1:0] index_i,
  output logic [LANES*SEL_W-1:0]  sel_o
);

  localparam int unsigned HI_W = LANE_W - SEL_W;

  // upper index bits are deliberately discarded
  logic [LANES*HI_W-1:0] hi_unused;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_o[g*SEL_W +: SEL_W]    = index_i[g*LANE_W +: SEL_W];
    assign hi_unused[g*HI_W +: HI_W]  = index_i[g*LANE_W+SEL_W +: HI_W];
  end

endmodule

// File: rtl/lperm_lane_mux.sv
module lperm_lane_mux
  import lperm_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned SEL_W  = $clog2(DEF_LANES)
) (
  input  logic [LANES*LANE_W-1:0] data_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [LANE_W-1:0]       lane_o
);

  always_comb begin
    lane_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (sel_i == SEL_W'(k)) begin
        lane_o = data_i[k*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/lperm_legality.sv
module lperm_legality
  import lperm_pkg::*;
(
  input  logic       valid_i,
  input  lperm_enc_t enc_i,
  output logic       fault_o
);

  lperm_enc_e status;

  always_comb begin
    unique case ({enc_i.wide_elem, ~enc_i.len_full})
      2'b00:   status = ENC_OK;
      2'b01:   status = ENC_SHORT;
      2'b10:   status = ENC_WIDE;
      default: status = ENC_BOTH;
    endcase
  end

  assign fault_o = valid_i && (status != ENC_OK);

endmodule

// File: rtl/lperm_out_stage.sv
module lperm_out_stage
  import lperm_pkg::*;
#(
  parameter int unsigned W = DEF_LANES * DEF_LANE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic         fault_i,
  input  logic [W-1:0] result_i,
  output logic         valid_o,
  output logic         fault_o,
  output logic [W-1:0] result_o
);

  logic         valid_d, valid_q;
  logic         fault_d, fault_q;
  logic [W-1:0] result_d, result_q;

  // next-state: result register loads only on a request
  always_comb begin
    valid_d  = valid_i;
    fault_d  = fault_i;
    result_d = result_q;
    if (valid_i) begin
      result_d = result_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      fault_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q  <= valid_d;
      fault_q  <= fault_d;
      result_q <= result_d;
    end
  end

  assign valid_o  = valid_q;
  assign fault_o  = fault_q;
  assign result_o = result_q;

endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
  import lperm_pkg::*;
#(
  parameter int unsigned LANES   = DEF_LANES,
  parameter int unsigned LANE_W  = DEF_LANE_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] in_data,
  input  logic [LANES*LANE_W-1:0] in_index,
  input  logic                    in_len_full,
  input  logic                    in_wide_elem,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] out_result,
  output logic                    out_fault
);

  localparam int unsigned SEL_W = $clog2(LANES);
  localparam int unsigned VEC_W = LANES * LANE_W;

  logic [LANES*SEL_W-1:0] lane_sel;
  logic [VEC_W-1:0]       permuted;
  logic [VEC_W-1:0]       result_nx;
  logic                   fault_nx;
  lperm_enc_t             enc;

  assign enc.len_full  = in_len_full;
  assign enc.wide_elem = in_wide_elem;

  lperm_index_decode #(
    .LANES (LANES),
    .LANE_W(LANE_W),
    .SEL_W (SEL_W)
  ) u_decode (
    .index_i(in_index),
    .sel_o  (lane_sel)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_mux
    lperm_lane_mux #(
      .LANES (LANES),
      .LANE_W(LANE_W),
      .SEL_W (SEL_W)
    ) u_mux (
      .data_i(in_data),
      .sel_i (lane_sel[g*SEL_W +: SEL_W]),
      .lane_o(permuted[g*LANE_W +: LANE_W])
    );
  end

  lperm_legality u_legal (
    .valid_i(in_valid),
    .enc_i  (enc),
    .fault_o(fault_nx)
  );

  // an illegal request never exposes permuted data
  assign result_nx = fault_nx ? '0 : permuted;

  if (REG_OUT) begin : g_reg
    lperm_out_stage #(
      .W(VEC_W)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (in_valid),
      .fault_i (fault_nx),
      .result_i(result_nx),
      .valid_o (out_valid),
      .fault_o (out_fault),
      .result_o(out_result)
    );
  end else begin : g_comb
    assign out_valid  = in_valid;
    assign out_fault  = fault_nx;
    assign out_result = result_nx;
  end

endmodule

// File: rtl/lperm_checker.sv
module lperm_checker #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned LANE_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [LANES*LANE_W-1:0] in_data,
  input logic [LANES*LANE_W-1:0] in_index,
  input logic                    in_len_full,
  input logic                    in_wide_elem,
  input logic                    out_valid,
  input logic [LANES*LANE_W-1:0] out_result,
  input logic                    out_fault
);

  localparam int unsigned SEL_W = $clog2(LANES);

  logic                    past_ok;
  logic [LANES*LANE_W-1:0] model;
  logic                    legal_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // shift-based lane model, independent of the mux structure
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      model[l*LANE_W +: LANE_W] =
        LANE_W'(in_data >> (LANE_W * int'(in_index[l*LANE_W +: SEL_W])));
    end
  end

  assign legal_req = in_valid && in_len_full && !in_wide_elem;

  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_result == '0));

  p_fault_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_valid);

  if (REG_OUT) begin : g_reg_chk
    p_reset_clear_r9: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && !out_fault));

    p_valid_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (out_valid == $past(in_valid)));

    p_short_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(in_valid && !in_len_full)) |-> out_fault);

    p_wide_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(in_valid && in_wide_elem)) |-> out_fault);

    p_lane_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(legal_req)) |-> (out_result == $past(model)));

    p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(in_valid)) |-> $stable(out_result));
  end else begin : g_comb_chk
    p_valid_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);

    p_lane_select_comb_r1: assert property (@(posedge clk) disable iff (!rst_n)
      legal_req |-> (out_result == model));

    p_short_fault_comb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_len_full) |-> out_fault);
  end

endmodule

bind lane_permute_unit lperm_checker #(
  .LANES  (LANES),
  .LANE_W (LANE_W),
  .REG_OUT(REG_OUT)
) u_lperm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .in_index    (in_index),
  .in_len_full (in_len_full),
  .in_wide_elem(in_wide_elem),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_fault   (out_fault)
);

// File: tb/test_lane_permute_unit.sv
`timescale 1ns/1ps
module test_lane_permute_unit;

  localparam int N  = 8;
  localparam int LW = 32;
  localparam int VW = N * LW;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [VW-1:0] in_data;
  logic [VW-1:0] in_index;
  logic          in_len_full;
  logic          in_wide_elem;

  logic          r_valid, r_fault;
  logic [VW-1:0] r_result;
  logic          c_valid, c_fault;
  logic [VW-1:0] c_result;

  int checks;
  int errors;

  lane_permute_unit #(.LANES(N), .LANE_W(LW), .REG_OUT(1'b1)) i_lane_permute_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_index(in_index), .in_len_full(in_len_full), .in_wide_elem(in_wide_elem),
    .out_valid(r_valid), .out_result(r_result), .out_fault(r_fault)
  );

  lane_permute_unit #(.LANES(N), .LANE_W(LW), .REG_OUT(1'b0)) i_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_index(in_index), .in_len_full(in_len_full), .in_wide_elem(in_wide_elem),
    .out_valid(c_valid), .out_result(c_result), .out_fault(c_fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [VW-1:0] ref_perm(input logic [VW-1:0] d, input logic [VW-1:0] ix);
    logic [VW-1:0] r;
    for (int l = 0; l < N; l++) begin
      r[l*LW +: LW] = d[int'(ix[l*LW +: 3])*LW +: LW];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int l = 0; l < N; l++) v[l*LW +: LW] = $urandom;
    return v;
  endfunction

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request: checks the same-cycle copy before the edge, the registered copy after it
  task automatic run_one(input logic v, input logic [VW-1:0] d, input logic [VW-1:0] ix,
                         input logic len, input logic wide, input string tag);
    logic          ef;
    logic [VW-1:0] er;
    ef = v && (!len || wide);
    er = ef ? '0 : ref_perm(d, ix);
    @(negedge clk);
    in_valid = v; in_data = d; in_index = ix; in_len_full = len; in_wide_elem = wide;
    #1;
    chk1({tag, " comb valid R8"}, c_valid, v);
    chk1({tag, " comb fault"}, c_fault, ef);
    if (v) chkv({tag, " comb result"}, c_result, er);
    @(posedge clk);
    #2;
    chk1({tag, " reg valid R8"}, r_valid, v);
    chk1({tag, " reg fault"}, r_fault, ef);
    if (v) chkv({tag, " reg result"}, r_result, er);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; in_index = '0; in_len_full = 1'b1; in_wide_elem = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk1("R9 reset valid", r_valid, 1'b0);
    chk1("R9 reset fault", r_fault, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_identity_reverse();
    logic [VW-1:0] d, ix_id, ix_rev;
    d = rand_vec();
    for (int l = 0; l < N; l++) begin
      ix_id[l*LW +: LW]  = LW'(l);
      ix_rev[l*LW +: LW] = LW'(N - 1 - l);
    end
    run_one(1'b1, d, ix_id, 1'b1, 1'b0, "R1 identity");
    run_one(1'b1, d, ix_rev, 1'b1, 1'b0, "R1 reverse");
  endtask

  task automatic t_random_upper();
    for (int it = 0; it < 40; it++) begin
      run_one(1'b1, rand_vec(), rand_vec(), 1'b1, 1'b0, "R1 R2 random index upper bits");
    end
  endtask

  task automatic t_upper_ignored();
    logic [VW-1:0] d, lo, hi;
    d = rand_vec();
    lo = rand_vec();
    for (int l = 0; l < N; l++) lo[l*LW+3 +: LW-3] = '0;
    hi = lo;
    for (int l = 0; l < N; l++) hi[l*LW+3 +: LW-3] = '1;
    run_one(1'b1, d, lo, 1'b1, 1'b0, "R2 upper zero");
    run_one(1'b1, d, hi, 1'b1, 1'b0, "R2 upper ones");
    chkv("R2 same result both uppers", r_result, ref_perm(d, lo));
  endtask

  task automatic t_broadcast();
    logic [VW-1:0] d, ix;
    d = rand_vec();
    for (int s = 0; s < N; s++) begin
      for (int l = 0; l < N; l++) ix[l*LW +: LW] = LW'(s) | ($urandom << 3);
      run_one(1'b1, d, ix, 1'b1, 1'b0, "R3 broadcast");
    end
    for (int l = 0; l < N; l++) ix[l*LW +: LW] = LW'(l[0] ? 6 : 1);
    run_one(1'b1, d, ix, 1'b1, 1'b0, "R3 two-source duplicate");
  endtask

  task automatic t_encodings();
    logic [VW-1:0] d, ix;
    d = rand_vec(); ix = rand_vec();
    run_one(1'b1, d, ix, 1'b1, 1'b0, "R6 legal len1 wide0");
    run_one(1'b1, d, ix, 1'b0, 1'b0, "R4 R6 len0 wide0");
    run_one(1'b1, d, ix, 1'b1, 1'b1, "R5 R6 len1 wide1");
    run_one(1'b1, d, ix, 1'b0, 1'b1, "R4 R5 R6 len0 wide1");
    chkv("R6 fault zeroes result", r_result, '0);
  endtask

  task automatic t_bit_exact();
    logic [VW-1:0] d, ix;
    d = {32'hFFFF_FFFF, 32'h7FC0_0001, 32'hFF80_0000, 32'h0000_0001,
         32'h8000_0000, 32'h7F80_0000, 32'h007F_FFFF, 32'hFFBF_FFFF};
    for (int l = 0; l < N; l++) ix[l*LW +: LW] = LW'((l * 3 + 1) % N);
    run_one(1'b1, d, ix, 1'b1, 1'b0, "R7 special patterns");
  endtask

  task automatic t_latency_hold();
    logic [VW-1:0] d, ix, held;
    d = rand_vec(); ix = rand_vec();
    idle();
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_index = ix; in_len_full = 1'b1; in_wide_elem = 1'b0;
    #1;
    chk1("R8 registered not yet valid", r_valid, 1'b0);
    chk1("R8 comb valid now", c_valid, 1'b1);
    @(posedge clk);
    #2;
    chk1("R8 registered valid one cycle later", r_valid, 1'b1);
    held = ref_perm(d, ix);
    chkv("R8 registered result", r_result, held);
    @(negedge clk);
    in_valid = 1'b0; in_data = rand_vec(); in_index = rand_vec();
    in_len_full = 1'b0; in_wide_elem = 1'b1;
    #1;
    chk1("R10 comb no fault when idle", c_fault, 1'b0);
    @(posedge clk);
    #2;
    chk1("R8 registered valid drops", r_valid, 1'b0);
    chk1("R10 registered no fault when idle", r_fault, 1'b0);
    chkv("R11 result held while idle", r_result, held);
    @(posedge clk);
    #2;
    chkv("R11 result still held", r_result, held);
  endtask

  task automatic t_async_reset();
    run_one(1'b1, rand_vec(), rand_vec(), 1'b0, 1'b0, "R4 before reset");
    #1;
    rst_n = 1'b0;
    #1;
    chk1("R9 async clear valid", r_valid, 1'b0);
    chk1("R9 async clear fault", r_fault, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_identity_reverse();
    t_random_upper();
    t_upper_ignored();
    t_broadcast();
    t_encodings();
    t_bit_exact();
    t_latency_hold();
    t_async_reset();
    idle();
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule